// File: doc/BRIEF.md
# Power-Up Sequencer with Clamped Start Delay

This block orders the start of a regulator controller once its supply is detected. After power-good rises, it spends a fixed window in a configuration-load phase. During that window an enable request is ignored. It then spends one cycle choosing the start delay, either from a stored setting or from a three-level strap. After that it signals ready and waits for enable. Once enabled, it waits out a start delay that can never be shorter than a fixed floor. It then raises a digital setpoint code one step at a time until the code reaches the target. The spacing of the steps is set by a programmed ramp time.

All durations are counted in pulses of a slow timebase input `tick`, which is nominally 1 ms. This lets a system scale every interval without touching the logic. The states, with their output codes, are OFF (0), CFGLOAD (1), STRAP (2), READY (3), WAIT (4), RAMP (5) and ON (6). The transitions are:
- OFF→CFGLOAD when power is good.
- CFGLOAD→STRAP when the load window expires.
- STRAP→READY unconditionally.
- READY→WAIT on enable.
- WAIT→RAMP when the delay expires.
- RAMP→ON when the setpoint equals the target.
- WAIT, RAMP or ON →READY when enable is withdrawn.
- Any state →OFF when power-good is lost.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the state is OFF (code 0), with `ready`, `ramp_active`, `done` and `setpoint` all zero. A high `pwr_good` moves OFF to CFGLOAD (code 1) on the next clock.
- R2: CFGLOAD lasts exactly MEMCHK_TICKS ticks (15 by default), and `en` has no effect during it.
- R3: STRAP (code 2) lasts one cycle and is followed by READY (code 3). `ready` is high exactly in READY and `ramp_active` exactly in RAMP (code 5).
- R4: The configured delay is captured in STRAP. If `cfg_valid` is high it is `cfg_dly`. Otherwise `dly_strap` selects it: 2'b00 gives 10 ticks, 2'b10 gives 50, 2'b01 gives 100, and 2'b11 is treated as 2'b10.
- R5: Enable moves READY to WAIT (code 4). RAMP is entered after exactly max(MIN_DLY_TICKS, configured delay) ticks in WAIT, with MIN_DLY_TICKS = 7.
- R6: `tgt_code` and `ramp_ticks` are latched when RAMP begins. The step interval is max(1, ramp_ticks / tgt_code) ticks, rounded down. The setpoint rises by one per interval, never decreases in RAMP, and never exceeds the target.
- R7: When the setpoint equals the target, the state moves to ON (code 6) on the next clock and `done` is high for exactly that first ON cycle. A target of 0 reaches ON with 0 ticks spent in RAMP.
- R8: Withdrawing `en` in WAIT, RAMP or ON moves the state to READY on the next clock with `setpoint` 0. This takes priority over a delay expiring in the same cycle.
- R9: A low `pwr_good` moves any state to OFF on the next clock with `setpoint` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| pwr_good | input | 1 | Supply detected |
| en | input | 1 | Start request |
| cfg_valid | input | 1 | Stored settings are present |
| dly_strap | input | 2 | Three-level delay strap code |
| cfg_dly | input | TIME_W | Stored start delay in ticks |
| tgt_code | input | CODE_W | Final setpoint code |
| ramp_ticks | input | TIME_W | Ramp duration in ticks |
| state | output | 3 | Current sequencer state code |
| ready | output | 1 | Waiting for enable |
| ramp_active | output | 1 | Setpoint is ramping |
| done | output | 1 | One-cycle pulse on reaching target |
| setpoint | output | CODE_W | Output setpoint code |

## Verification
Two functions can fall in the same cycle: expiry of the start delay and withdrawal of enable. The bench counts ticks in WAIT and drops `en` in the very cycle that carries the last tick of the delay. The expected outcome is READY with zero setpoint; a RAMP entry in that cycle counts as a failure. Loss of power-good in the middle of a ramp is also provoked, and the bench expects OFF rather than a further step or READY.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_CFGLOAD = 3'd1,
        ST_STRAP   = 3'd2,
        ST_READY   = 3'd3,
        ST_WAIT    = 3'd4,
        ST_RAMP    = 3'd5,
        ST_ON      = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_HIGH = 2'b01,
        STRAP_OPEN = 2'b10,
        STRAP_RSVD = 2'b11
    } strap_e;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic [TIME_W-1:0] limit,
    output logic [TIME_W-1:0] cnt,
    output logic              expire
);
    logic [TIME_W-1:0] cnt_q;

    assign cnt    = cnt_q;
    assign expire = run && tick && (cnt_q == limit - TIME_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + TIME_W'(1);
        end
    end

    // the count never runs past the limit while the window is open (R2, R5)
    p_cnt_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q < limit);

endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
    parameter int CODE_W = 8,
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic              run,
    input  logic              keep,
    input  logic [CODE_W-1:0] tgt_i,
    input  logic [TIME_W-1:0] ramp_i,
    output logic [CODE_W-1:0] sp_o,
    output logic              at_tgt_o
);
    logic [CODE_W-1:0] tgt_q, sp_q;
    logic [TIME_W-1:0] intv_q, icnt_q, intv_raw, intv_calc;

    always_comb begin
        intv_raw  = (tgt_i == '0) ? TIME_W'(1) : ramp_i / TIME_W'(tgt_i);
        intv_calc = (intv_raw == '0) ? TIME_W'(1) : intv_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            sp_q   <= '0;
            intv_q <= TIME_W'(1);
            icnt_q <= '0;
        end else if (load) begin
            tgt_q  <= tgt_i;
            intv_q <= intv_calc;
            sp_q   <= '0;
            icnt_q <= '0;
        end else if (!keep) begin
            sp_q   <= '0;
            icnt_q <= '0;
        end else if (run && tick) begin
            if (icnt_q == intv_q - TIME_W'(1)) begin
                icnt_q <= '0;
                if (sp_q < tgt_q) sp_q <= sp_q + CODE_W'(1);
            end else begin
                icnt_q <= icnt_q + TIME_W'(1);
            end
        end
    end

    assign sp_o     = sp_q;
    assign at_tgt_o = (sp_q == tgt_q);

    p_sp_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && keep && $past(run)) |=> sp_q >= $past(sp_q));

    p_sp_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> sp_q <= tgt_q);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int CODE_W         = 8,
    parameter int TIME_W         = 12,
    parameter int MEMCHK_TICKS   = 15,
    parameter int MIN_DLY_TICKS  = 7,
    parameter int DLY_LOW_TICKS  = 10,
    parameter int DLY_OPEN_TICKS = 50,
    parameter int DLY_HIGH_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pwr_good,
    input  logic              en,
    input  logic              cfg_valid,
    input  logic [1:0]        dly_strap,
    input  logic [TIME_W-1:0] cfg_dly,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic [TIME_W-1:0] ramp_ticks,
    output logic [2:0]        state,
    output logic              ready,
    output logic              ramp_active,
    output logic              done,
    output logic [CODE_W-1:0] setpoint
);
    localparam logic [TIME_W-1:0] MEMCHK_LIM = TIME_W'(MEMCHK_TICKS);
    localparam logic [TIME_W-1:0] MIN_DLY    = TIME_W'(MIN_DLY_TICKS);

    seq_state_e        state_q, state_d;
    logic [TIME_W-1:0] dly_cfg_q, eff_dly, tmr_limit, tmr_cnt;
    logic              tmr_run, tmr_exp, done_q;
    logic              rmp_load, rmp_run, rmp_keep, at_tgt;

    function automatic logic [TIME_W-1:0] strap_ticks(input logic [1:0] code);
        unique case (strap_e'(code))
            STRAP_LOW:  return TIME_W'(DLY_LOW_TICKS);
            STRAP_HIGH: return TIME_W'(DLY_HIGH_TICKS);
            default:    return TIME_W'(DLY_OPEN_TICKS);
        endcase
    endfunction

    // start delay is never shorter than the floor
    assign eff_dly   = (dly_cfg_q < MIN_DLY) ? MIN_DLY : dly_cfg_q;
    assign tmr_run   = (state_q == ST_CFGLOAD) || (state_q == ST_WAIT);
    assign tmr_limit = (state_q == ST_CFGLOAD) ? MEMCHK_LIM : eff_dly;

    pwr_seq_timer #(.TIME_W(TIME_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (tmr_run),
        .limit  (tmr_limit),
        .cnt    (tmr_cnt),
        .expire (tmr_exp)
    );

    assign rmp_load = (state_q == ST_WAIT) && (state_d == ST_RAMP);
    assign rmp_run  = (state_q == ST_RAMP);
    assign rmp_keep = (state_d == ST_RAMP) || (state_d == ST_ON);

    pwr_seq_ramp #(.CODE_W(CODE_W), .TIME_W(TIME_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (rmp_load),
        .run      (rmp_run),
        .keep     (rmp_keep),
        .tgt_i    (tgt_code),
        .ramp_i   (ramp_ticks),
        .sp_o     (setpoint),
        .at_tgt_o (at_tgt)
    );

    // next state: power loss first, then enable withdrawal, then timers
    always_comb begin
        state_d = state_q;
        if (!pwr_good) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_CFGLOAD;
                ST_CFGLOAD: if (tmr_exp) state_d = ST_STRAP;
                ST_STRAP:   state_d = ST_READY;
                ST_READY:   if (en) state_d = ST_WAIT;
                ST_WAIT:    if (!en) state_d = ST_READY;
                            else if (tmr_exp) state_d = ST_RAMP;
                ST_RAMP:    if (!en) state_d = ST_READY;
                            else if (at_tgt) state_d = ST_ON;
                ST_ON:      if (!en) state_d = ST_READY;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // registered outputs and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_cfg_q <= '0;
            done_q    <= 1'b0;
        end else begin
            if (state_q == ST_STRAP)
                dly_cfg_q <= cfg_valid ? cfg_dly : strap_ticks(dly_strap);
            done_q <= (state_q == ST_RAMP) && (state_d == ST_ON);
        end
    end

    always_comb begin
        state       = state_q;
        ready       = (state_q == ST_READY);
        ramp_active = (state_q == ST_RAMP);
        done        = done_q;
    end

    p_en_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFGLOAD) |=> (state_q inside {ST_CFGLOAD, ST_STRAP, ST_OFF}));

    p_strap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRAP) |=> (state_q != ST_STRAP));

    p_min_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && tmr_exp) |-> (tmr_cnt >= MIN_DLY - TIME_W'(1)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {ST_WAIT, ST_RAMP, ST_ON}) && !en && pwr_good)
        |=> (state_q == ST_READY && setpoint == '0));

    p_pg_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state_q == ST_OFF && setpoint == '0));

endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;
    localparam int CODE_W = 8;
    localparam int TIME_W = 12;
    localparam int S_OFF = 0, S_CFG = 1, S_STRAP = 2, S_READY = 3,
                   S_WAIT = 4, S_RAMP = 5, S_ON = 6;

    logic clk = 1'b0;
    logic rst_n, tick, pwr_good, en, cfg_valid;
    logic [1:0] dly_strap;
    logic [TIME_W-1:0] cfg_dly, ramp_ticks;
    logic [CODE_W-1:0] tgt_code, setpoint;
    logic [2:0] state;
    logic ready, ramp_active, done;

    int checks = 0, errs = 0;
    int tcnt = 0, mono_err = 0, done_err = 0, prev_st = 0, prev_sp = 0;
    logic mon_on = 1'b0;
    logic [1:0] tdiv = '0;

    typedef struct {
        int    st;
        int    ticks;
        int    spv;
        string req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    pwr_seq_top #(.CODE_W(CODE_W), .TIME_W(TIME_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .en(en),
        .cfg_valid(cfg_valid), .dly_strap(dly_strap), .cfg_dly(cfg_dly),
        .tgt_code(tgt_code), .ramp_ticks(ramp_ticks), .state(state),
        .ready(ready), .ramp_active(ramp_active), .done(done), .setpoint(setpoint)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void push(input int s, input int t, input int spv, input string r);
        exp_t e;
        e.st = s; e.ticks = t; e.spv = spv; e.req = r;
        q.push_back(e);
    endfunction

    function automatic int ramp_len(input int tgt, input int rt);
        int iv;
        if (tgt == 0) return 0;
        iv = rt / tgt;
        if (iv < 1) iv = 1;
        return iv * tgt;
    endfunction

    // scoreboard monitor: pops one expected item per state change
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (int'(state) != prev_st) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1", "unexpected transition to", int'(state), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(int'(state) == e.st, e.req, "next state", int'(state), e.st);
                    if (e.ticks >= 0)
                        check(tcnt == e.ticks, e.req, "ticks in previous state", tcnt, e.ticks);
                    if (e.spv >= 0)
                        check(int'(setpoint) == e.spv, e.req, "setpoint", int'(setpoint), e.spv);
                    if (int'(state) == S_ON)
                        check(done == 1'b1, "R7", "done on first ON cycle", int'(done), 1);
                    check(ready == (int'(state) == S_READY), "R3", "ready flag", int'(ready),
                          int'(int'(state) == S_READY));
                    check(ramp_active == (int'(state) == S_RAMP), "R3", "ramp_active flag",
                          int'(ramp_active), int'(int'(state) == S_RAMP));
                end
                if (prev_st == S_RAMP)
                    check(mono_err == 0, "R6", "setpoint decreases in ramp", mono_err, 0);
                tcnt = 0;
            end
            if (tick) tcnt++;
            if (int'(state) == S_RAMP && prev_st == S_RAMP && int'(setpoint) < prev_sp)
                mono_err++;
            if (done && !(int'(state) == S_ON && prev_st != S_ON)) done_err++;
            prev_st = int'(state);
            prev_sp = int'(setpoint);
        end
    end

    task automatic at_pos();
        @(posedge clk); #2;
    endtask

    task automatic wait_st(input int s);
        @(negedge clk);
        while (int'(state) != s) @(negedge clk);
    endtask

    task automatic power_up(input logic [1:0] strap, input logic cv, input int cd);
        dly_strap = strap; cfg_valid = cv; cfg_dly = TIME_W'(cd);
        push(S_CFG, -1, 0, "R1");
        push(S_STRAP, 15, -1, "R2");
        push(S_READY, 0, 0, "R3");
        at_pos(); pwr_good = 1'b1;
        wait_st(S_READY);
    endtask

    task automatic power_down();
        push(S_OFF, -1, 0, "R9");
        at_pos(); pwr_good = 1'b0; en = 1'b0;
        wait_st(S_OFF);
    endtask

    task automatic run_full(input int eff, input int tgt, input int rt, input string dreq);
        tgt_code = CODE_W'(tgt); ramp_ticks = TIME_W'(rt);
        push(S_WAIT, -1, 0, "R5");
        push(S_RAMP, eff, 0, dreq);
        push(S_ON, ramp_len(tgt, rt), tgt, "R7");
        at_pos(); en = 1'b1;
        wait_st(S_ON);
        repeat (3) @(negedge clk);
        push(S_READY, -1, 0, "R8");
        at_pos(); en = 1'b0;
        wait_st(S_READY);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; pwr_good = 1'b0; en = 1'b0; cfg_valid = 1'b0;
        dly_strap = 2'b00; cfg_dly = '0; tgt_code = '0; ramp_ticks = '0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(int'(state) == S_OFF, "R1", "reset state", int'(state), S_OFF);
        check(!ready && !ramp_active && !done, "R1", "reset flags",
              int'({ready, ramp_active, done}), 0);
        check(setpoint == '0, "R1", "reset setpoint", int'(setpoint), 0);
        prev_st = S_OFF; mon_on = 1'b1;

        // R2: enable raised inside the load window is ignored; strap low -> 10
        tgt_code = 8'd5; ramp_ticks = 12'd10; dly_strap = 2'b00; cfg_valid = 1'b0;
        push(S_CFG, -1, 0, "R1");
        push(S_STRAP, 15, -1, "R2");
        push(S_READY, 0, 0, "R3");
        push(S_WAIT, 0, 0, "R5");
        push(S_RAMP, 10, 0, "R4");
        push(S_ON, 10, 5, "R6");
        at_pos(); pwr_good = 1'b1;
        repeat (8) at_pos();
        en = 1'b1;
        wait_st(S_ON);
        repeat (2) @(negedge clk);
        push(S_READY, -1, 0, "R8");
        at_pos(); en = 1'b0;
        wait_st(S_READY);

        // R4: strap open -> 50; high -> 100; reserved -> 50
        power_down(); power_up(2'b10, 1'b0, 0); run_full(50, 4, 9, "R4");
        power_down(); power_up(2'b01, 1'b0, 0); run_full(100, 3, 3, "R4");
        power_down(); power_up(2'b11, 1'b0, 0); run_full(50, 1, 5, "R4");

        // R5: short stored delay clamped to 7; R7 target 0
        power_down(); power_up(2'b01, 1'b1, 3); run_full(7, 0, 4, "R5");

        // stored delay longer than floor used as given
        power_down(); power_up(2'b00, 1'b1, 20); run_full(20, 6, 20, "R6");

        // R8: abort mid-ramp
        tgt_code = 8'd6; ramp_ticks = 12'd20;
        push(S_WAIT, -1, 0, "R5");
        push(S_RAMP, 20, 0, "R5");
        push(S_READY, -1, 0, "R8");
        at_pos(); en = 1'b1;
        wait_st(S_RAMP);
        while (setpoint != 8'd3) @(negedge clk);
        at_pos(); en = 1'b0;
        wait_st(S_READY);

        // R8: abort inside the delay
        push(S_WAIT, -1, 0, "R5");
        push(S_READY, -1, 0, "R8");
        at_pos(); en = 1'b1;
        wait_st(S_WAIT);
        repeat (10) @(negedge clk);
        at_pos(); en = 1'b0;
        wait_st(S_READY);

        // R8: enable drops in the same cycle as the delay's last tick
        push(S_WAIT, -1, 0, "R5");
        push(S_READY, 20, 0, "R8");
        at_pos(); en = 1'b1;
        wait_st(S_WAIT);
        n = tick ? 1 : 0;
        while (n < 20) begin
            @(negedge clk);
            if (tick) n++;
        end
        en = 1'b0;
        wait_st(S_READY);
        repeat (8) @(negedge clk);
        check(int'(state) == S_READY, "R8", "stays ready after coincident abort",
              int'(state), S_READY);

        // R9: power loss mid-ramp
        push(S_WAIT, -1, 0, "R5");
        push(S_RAMP, 20, 0, "R5");
        push(S_OFF, -1, 0, "R9");
        at_pos(); en = 1'b1;
        wait_st(S_RAMP);
        while (setpoint != 8'd2) @(negedge clk);
        at_pos(); pwr_good = 1'b0; en = 1'b0;
        wait_st(S_OFF);

        repeat (10) @(negedge clk);
        check(q.size() == 0, "R1", "expected transitions left over", q.size(), 0);
        check(done_err == 0, "R7", "done outside first ON cycle", done_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule